// File: doc/BRIEF.md
# Eight-Bit Timer/Counter with Shared Prescaler

This block is an 8-bit free-running timer/counter. It counts either the instruction-cycle enable or edges on an external pin. A single binary prescaler serves two owners: either the counter or a watchdog counter. A select bit in a 6-bit mode register picks the owner. The prescaler's ratio table moves by one step depending on the owner. Under the counter it divides by 2 through 256. Under the watchdog it divides by 1 through 128. The prescaler's current owner loses nothing: the other consumer then counts its own events directly.

Software loads the mode register through a write port and can preload the counter. It can also restart the watchdog with a clear strobe. The block gives back three things: the live count, a one-cycle wrap pulse that a neighbouring interrupt controller latches into its timer flag, and a one-cycle watchdog time-out pulse. The watchdog time base is a tick that comes from outside the block.

Top module: `tmr8_shared_pscl`

## Requirements
- R1: On a synchronous active-low reset the count is 0, both pulses are low, and the mode register holds all ones. All ones means ratio code 7, prescaler owned by the watchdog, external source, and falling edge.
- R2: Mode bit 5 selects the count source. With bit 5 = 0, every cycle in which `cyc_en` is high is one source event.
- R3: With bit 5 = 1, events come from `ext_pin` after a two-flop synchronizer, and `cyc_en` has no effect. Mode bit 4 = 0 counts low-to-high transitions and 1 counts high-to-low transitions. An edge advances the count three clock edges after the pin changes.
- R4: With mode bit 3 = 0, the prescaler belongs to the counter. The counter then advances once per 2^(code+1) source events, where code is mode bits 2:0 (000 gives 1:2 and 111 gives 1:256).
- R5: With mode bit 3 = 1, the prescaler belongs to the watchdog and divides watchdog ticks by 2^code (000 gives 1:1 and 111 gives 1:128). The counter then advances on every source event.
- R6: A counter write loads `cnt_wdata` at the next edge, overriding any increment in that cycle. When the counter owns the prescaler, the write also clears the prescaler.
- R7: The count wraps from 255 to 0. The wrap raises `ovf_pulse` for exactly the one cycle in which the count first reads 0.
- R8: The watchdog counter has WD_BITS bits. It advances once per watchdog event: a raw `wd_tick` when the counter owns the prescaler, or a prescaler output otherwise. When it wraps from all ones to 0, `wd_timeout` is high for one cycle.
- R9: `wd_clr` zeroes the watchdog counter and overrides both an advance and a time-out in that cycle. When the watchdog owns the prescaler, `wd_clr` also clears the prescaler.
- R10: A mode write takes effect at the next edge and clears the prescaler. Data bits 7:6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cyc_en | input | 1 | Instruction-cycle enable, the internal count source |
| ext_pin | input | 1 | Asynchronous external count pin |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode data: [2:0] ratio code, [3] owner (1 = watchdog), [4] edge (1 = falling), [5] source (1 = pin) |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | 8 | Counter preload value |
| wd_clr | input | 1 | Watchdog clear strobe |
| wd_tick | input | 1 | Watchdog time-base tick |
| count | output | 8 | Current counter value |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |
| wd_timeout | output | 1 | One-cycle watchdog time-out pulse |

## Verification
The embedded assertions cover several per-cycle properties:
- A wrap pulse only coincides with a zero count.
- A preload always lands.
- Without a write, the count moves by at most one per cycle.
- A watchdog clear always leaves a zero count with no time-out.

Some behaviours depend on the sequence of inputs and only the bench's scenarios can show them. These are the ratio tables under each owner, the one-step offset between them, edge polarity, the synchronizer latency, and the prescaler clears caused by writes and mode changes. The bench shows them by comparing every output against a behavioural model on every cycle.

// File: rtl/tmr_pkg.sv
// Shared types for the timer/counter: the mode register layout and its reset value.
package tmr_pkg;
    localparam int PS_BITS = 3;

    typedef struct packed {
        logic                src_ext;   // 1: external pin, 0: instruction cycle
        logic                edge_fall; // 1: high-to-low, 0: low-to-high
        logic                psc_to_wd; // 1: prescaler owned by watchdog
        logic [PS_BITS-1:0]  code;      // ratio code
    } mode_t;

    localparam int MODE_W = $bits(mode_t);
    localparam logic [MODE_W-1:0] MODE_RST = '1;
endpackage

// File: rtl/pin_sync_edge.sv
// Two-flop synchronizer for an asynchronous pin followed by an edge detector.
// Assumes the pin is held at least two clocks per level to be seen.
module pin_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    logic s1, s2, s3;

    // Shift the pin through the synchronizer and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= pin_i;
            s2 <= s1;
            s3 <= s2;
        end
    end

    // Compare the synchronized sample with the previous one.
    always_comb begin
        rise_o = s2 & ~s3;
        fall_o = ~s2 & s3;
    end
endmodule

// File: rtl/shared_prescaler.sv
// Binary prescaler. It emits one pulse per 2^(code+extra) input events.
// Assumes that a code change is always accompanied by clr_i.
module shared_prescaler #(
    parameter int PS_BITS = 3,
    localparam int CW = 2 ** PS_BITS
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PS_BITS-1:0] code_i,
    input  logic               extra_i,
    input  logic               evt_i,
    input  logic               clr_i,
    output logic               pulse_o
);
    logic [CW-1:0]    pcnt;
    logic [CW-1:0]    mask;
    logic [PS_BITS:0] shift;

    // Build the low-bit mask whose all-ones state marks the last event of a period.
    always_comb begin
        shift   = {1'b0, code_i} + {{PS_BITS{1'b0}}, extra_i};
        mask    = {CW{1'b1}} >> (CW - int'(shift));
        pulse_o = evt_i && ((pcnt & mask) == mask);
    end

    // Count input events; a clear wins over counting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i)
            pcnt <= '0;
        else if (evt_i)
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/wdog_count.sv
// Watchdog counter. It advances on each event and pulses on wrap; a clear wins.
module wdog_count #(
    parameter int WD_BITS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic timeout_o
);
    logic [WD_BITS-1:0] wcnt;

    // Advance the counter, flag the wrap and honour the clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wcnt      <= '0;
            timeout_o <= 1'b0;
        end else begin
            timeout_o <= evt_i && (&wcnt);
            if (evt_i)
                wcnt <= wcnt + 1'b1;
        end
    end

    // R8
    wd_wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> (wcnt == '0));
    // R9
    wd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (wcnt == '0 && !timeout_o));
endmodule

// File: rtl/tmr8_shared_pscl.sv
// Eight-bit timer/counter with a prescaler that the counter and the watchdog share.
// It holds the mode register, picks the source, routes the prescaler and keeps the count.
// Assumes wd_tick and cyc_en are synchronous one-clock strobes.
module tmr8_shared_pscl #(
    parameter int CNT_W   = 8,
    parameter int WD_BITS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ext_pin,
    input  logic             mode_we,
    input  logic [7:0]       mode_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             wd_clr,
    input  logic             wd_tick,
    output logic [CNT_W-1:0] count,
    output logic             ovf_pulse,
    output logic             wd_timeout
);
    import tmr_pkg::*;

    mode_t mode;
    logic  pin_rise, pin_fall;
    logic  src_evt, psc_in, psc_pulse, psc_clr;
    logic  tmr_evt, wd_evt;

    // Hold the mode register; bits above the layout are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode <= mode_t'(MODE_RST);
        else if (mode_we)
            mode <= mode_t'(mode_wdata[MODE_W-1:0]);
    end

    pin_sync_edge u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_pin),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    // Select the source event and route the prescaler between its two owners.
    always_comb begin
        if (mode.src_ext)
            src_evt = mode.edge_fall ? pin_fall : pin_rise;
        else
            src_evt = cyc_en;
        psc_in  = mode.psc_to_wd ? wd_tick : src_evt;
        psc_clr = mode_we || (mode.psc_to_wd ? wd_clr : cnt_we);
        tmr_evt = mode.psc_to_wd ? src_evt : psc_pulse;
        wd_evt  = mode.psc_to_wd ? psc_pulse : wd_tick;
    end

    shared_prescaler #(.PS_BITS(PS_BITS)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .code_i  (mode.code),
        .extra_i (~mode.psc_to_wd),
        .evt_i   (psc_in),
        .clr_i   (psc_clr),
        .pulse_o (psc_pulse)
    );

    // Keep the count: a write wins, otherwise advance and flag the wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count     <= '0;
            ovf_pulse <= 1'b0;
        end else if (cnt_we) begin
            count     <= cnt_wdata;
            ovf_pulse <= 1'b0;
        end else begin
            ovf_pulse <= tmr_evt && (&count);
            if (tmr_evt)
                count <= count + 1'b1;
        end
    end

    wdog_count #(.WD_BITS(WD_BITS)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_i     (wd_evt),
        .clr_i     (wd_clr),
        .timeout_o (wd_timeout)
    );

    // R7
    ovf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> (count == '0));
    // R6
    cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (count == $past(cnt_wdata)));
    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_we |=> (count == $past(count) || count == $past(count) + 1'b1));
endmodule

// File: tb/sim_tmr8_shared_pscl.sv
// Bench: a behavioural reference model advanced on each rising edge, compared on each falling edge.
module sim_tmr8_shared_pscl;
    localparam int WDB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0, ext_pin = 1'b0;
    logic       mode_we = 1'b0, cnt_we = 1'b0, wd_clr = 1'b0, wd_tick = 1'b0;
    logic [7:0] mode_wdata = '0, cnt_wdata = '0;
    logic [7:0] count;
    logic       ovf_pulse, wd_timeout;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit started = 0;

    always #4 clk = ~clk;

    tmr8_shared_pscl #(.CNT_W(8), .WD_BITS(WDB)) u0 (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ext_pin(ext_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata), .cnt_we(cnt_we),
        .cnt_wdata(cnt_wdata), .wd_clr(wd_clr), .wd_tick(wd_tick),
        .count(count), .ovf_pulse(ovf_pulse), .wd_timeout(wd_timeout)
    );

    // Reference model state
    int m_cnt, m_wd, m_pre, m_mode;
    bit m_ovf, m_to;
    bit pin_hist[$] = '{0, 0, 0};
    int ovf_seen = 0, to_seen = 0;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_cnt = 0; m_wd = 0; m_pre = 0; m_mode = 63; m_ovf = 0; m_to = 0;
            pin_hist = '{0, 0, 0};
        end else begin
            bit rise, fall, sev, own_wd, pin_ev, pp, tev, wev;
            int div;
            rise   = pin_hist[1] && !pin_hist[2];
            fall   = !pin_hist[1] && pin_hist[2];
            sev    = ((m_mode >> 5) & 1) ? (((m_mode >> 4) & 1) ? fall : rise) : cyc_en;
            own_wd = (m_mode >> 3) & 1;
            div    = own_wd ? (1 << (m_mode & 7)) : (2 << (m_mode & 7));
            pin_ev = own_wd ? wd_tick : sev;
            pp     = pin_ev && (m_pre + 1 == div);
            if (mode_we || (own_wd ? wd_clr : cnt_we)) m_pre = 0;
            else if (pin_ev) m_pre = pp ? 0 : m_pre + 1;
            tev = own_wd ? sev : pp;
            wev = own_wd ? pp : wd_tick;
            m_ovf = 0;
            if (cnt_we) m_cnt = cnt_wdata;
            else if (tev) begin
                m_ovf = (m_cnt == 255);
                m_cnt = (m_cnt + 1) % 256;
            end
            m_to = 0;
            if (wd_clr) m_wd = 0;
            else if (wev) begin
                m_to = (m_wd == (1 << WDB) - 1);
                m_wd = (m_wd + 1) % (1 << WDB);
            end
            if (mode_we) m_mode = mode_wdata & 63;
            pin_hist.push_front(ext_pin);
            void'(pin_hist.pop_back());
        end
        started = 1;
    end

    // Every-cycle comparison against the model.
    always @(negedge clk) begin
        if (started) begin
            chk("R2/R3/R4/R5 count", count, m_cnt);
            chk("R7 ovf_pulse", ovf_pulse, m_ovf);
            chk("R8 wd_timeout", wd_timeout, m_to);
            ovf_seen += ovf_pulse;
            to_seen  += wd_timeout;
        end
    end

    task automatic cycles(int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask
    task automatic wr_mode(logic [7:0] v);
        @(negedge clk); #1 mode_we = 1; mode_wdata = v;
        @(negedge clk); #1 mode_we = 0;
    endtask
    task automatic wr_cnt(logic [7:0] v);
        @(negedge clk); #1 cnt_we = 1; cnt_wdata = v;
        @(negedge clk); #1 cnt_we = 0;
    endtask
    task automatic ticks(int n, int gap);
        repeat (n) begin
            @(negedge clk); #1 wd_tick = 1;
            @(negedge clk); #1 wd_tick = 0;
            cycles(gap);
        end
    endtask
    task automatic toggles(int n);
        repeat (n) begin
            ext_pin = 1; cycles(4);
            ext_pin = 0; cycles(4);
        end
    endtask

    initial begin
        int c0, o0, t0;
        cycles(3);
        rst_n = 1;
        cycles(1);
        // R1: reset state
        chk("R1 count after reset", count, 0);
        chk("R1 ovf after reset", ovf_pulse, 0);
        chk("R1 timeout after reset", wd_timeout, 0);

        // R3/R5: default mode counts falling pin edges undivided; cyc_en ignored (R3)
        cyc_en = 1;
        toggles(3);
        cycles(4);
        chk("R3 falling edges counted, cyc_en ignored", count, 3);

        // R3: rising edges, pin source, watchdog owns the prescaler (code 0)
        wr_mode(8'b1110_1000);
        toggles(5);
        cycles(4);
        chk("R3 rising edges counted", count, 8);

        // R10/R2/R4: internal source, counter owns the prescaler, 1:2
        wr_mode(8'h00);
        wr_cnt(8'd0);
        c0 = count;
        cycles(20);
        chk("R4 ratio 1:2 over 20 cycles", count, c0 + 10);

        // R4: ratio 1:16 with a gapped cyc_en
        wr_mode(8'h03);
        wr_cnt(8'd0);
        repeat (64) begin cyc_en = 1; cycles(1); cyc_en = 0; cycles(1); end
        chk("R4 ratio 1:16", count, 4);

        // R6: a write clears the prescaler and loads the count
        wr_mode(8'h01);
        cyc_en = 1;
        cycles(3);
        wr_cnt(8'd100);
        chk("R6 preload visible", count, m_cnt);
        cycles(9);
        chk("R6 prescaler restarted", count, 102);

        // R7: wrap at 255 with a 1:2 prescaler
        wr_mode(8'h00);
        wr_cnt(8'd250);
        o0 = ovf_seen;
        cycles(16);
        chk("R7 one wrap pulse", ovf_seen - o0, 1);
        chk("R7 count after wrap", count, m_cnt);

        // R5: watchdog owns the prescaler at 1:4; counter counts each cycle
        cyc_en = 1;
        wr_mode(8'h0A);
        c0 = count;
        cycles(10);
        chk("R5 undivided count", count, (c0 + 10) % 256);
        t0 = to_seen;
        ticks(64, 1);
        cycles(2);
        chk("R8 timeouts at 1:4 over 64 ticks", to_seen - t0, 1);

        // R9: clear holds the watchdog away from time-out
        t0 = to_seen;
        repeat (6) begin ticks(12, 0); @(negedge clk); #1 wd_clr = 1; @(negedge clk); #1 wd_clr = 0; end
        chk("R9 no timeout with periodic clear", to_seen - t0, 0);

        // R8: counter owns the prescaler, so raw ticks reach the watchdog
        wr_mode(8'hC7);
        t0 = to_seen;
        ticks(32, 0);
        cycles(2);
        chk("R8 raw ticks timeout", to_seen - t0, 2);
        chk("R10 high mode bits ignored", count, m_cnt);

        // R9: clear in the same cycle as the wrapping tick wins
        ticks(15, 0);
        @(negedge clk); #1 wd_tick = 1; wd_clr = 1;
        @(negedge clk); #1 wd_tick = 0; wd_clr = 0;
        cycles(1);
        chk("R9 clear beats wrap", wd_timeout, 0);

        cycles(5);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule